// File: doc/BRIEF.md
# Timer interrupt router with legacy replacement

This block takes the expiry pulses of a small set of event timer channels and steers them onto a vector of interrupt lines. Each channel has a route field that selects its line. It also has a trigger type: level-type channels latch a status bit and hold the line until software clears it, and edge-type channels emit a one-cycle pulse. Each channel has its own enable and a switch that diverts it to message delivery. A channel switched to message delivery drives no line at all. A global enable gates every channel.

A global legacy-replacement switch hands two fixed lines to the first two channels. Channel 0 takes line 0 and channel 1 takes line 8. While the switch is on, the block blocks the two legacy sources it otherwise forwards: a periodic-timer input on line 0 and a real-time-clock input on line 8. The clock input's level is recorded at all times, so line 8 can show the correct level again as soon as legacy replacement ends. When several sources target one line, the line carries the OR of all of them. All outputs are registered.

Top module: `tmr_irq_router`

## Requirements
- R1: Outside legacy mode, an active channel n drives the line selected by its 5-bit route field, bits [5n+4:5n] of `tmr_route`.
- R2: While `legacy_en` is high, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Channel 2 keeps using its route field.
- R3: For a level-type channel (`tmr_level` bit 1), a fire pulse that is delivered sets its `sts_out` bit one cycle later and raises its line two cycles later. Both stay high until a `sts_clr` bit (write-one) clears them. If a fire and a clear arrive in the same cycle, the fire wins.
- R4: For an edge-type channel (`tmr_level` bit 0), a delivered fire raises its line for exactly one cycle, two cycles after the fire, and leaves its status bit at 0.
- R5: While a channel's `tmr_en` bit or `glb_en` is low, fire pulses have no effect and that channel's status bit is 0 from the next cycle on, so its line drops.
- R6: A channel whose `tmr_msg` bit is 1 drives no line, and a fire leaves its status unchanged. A rising `tmr_msg` bit clears that channel's status.
- R7: Outside legacy mode, a change of `pit_in` appears on line 0 two cycles later. In legacy mode nothing is forwarded. After legacy mode ends, line 0 stays low until `pit_in` changes again.
- R8: Outside legacy mode, line 8 follows `rtc_in` two cycles late. In legacy mode the input is masked but still recorded, and one cycle after legacy mode ends line 8 shows the recorded level.
- R9: A line targeted by several sources, whether channels or legacy inputs, is the OR of all of them.
- R10: Reset drives all lines and status bits low and clears the recorded clock level and the forwarded timer level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement switch |
| tmr_fire | input | 3 | One-cycle expiry pulse per channel |
| tmr_en | input | 3 | Per-channel interrupt enable |
| tmr_level | input | 3 | Per-channel type: 1 level, 0 edge |
| tmr_msg | input | 3 | Per-channel message delivery enable |
| tmr_route | input | 15 | Packed 5-bit route fields, channel n at [5n+4:5n] |
| sts_clr | input | 3 | Write-one-to-clear strobe for status bits |
| pit_in | input | 1 | Legacy periodic-timer source |
| rtc_in | input | 1 | Legacy real-time-clock source |
| irq_out | output | 32 | Registered interrupt lines |
| sts_out | output | 3 | Registered per-channel status bits |

## Verification
The bench covers several corner cases. It fires and clears in the same cycle, where a design that let the clear win would lose an interrupt. It turns message delivery on while a status bit is pending, where a wrong design would leave a line stuck high. It enters and leaves legacy mode with the clock input held high, where a design that stopped recording the level would bring line 8 back low. It leaves legacy mode with a steady timer input, where a design that forwarded the level straight through would raise line 0 with no new edge. It also points channels at lines 0 and 8 alongside the legacy sources, which catches a merge that drops one source in favour of another.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int unsigned TIR_NUM_CH    = 3;
  localparam int unsigned TIR_NUM_LINES = 32;
  localparam int unsigned TIR_LEG_LINE0 = 0;
  localparam int unsigned TIR_LEG_LINE1 = 8;

  typedef struct packed {
    logic en;
    logic level;
    logic msg;
  } ch_mode_t;
endpackage

// File: rtl/tir_chan.sv
module tir_chan
  import tir_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     glb_en,
  input  logic     fire_i,
  input  logic     clr_i,
  input  ch_mode_t mode_i,
  output logic     status_o,
  output logic     pulse_o
);
  logic status_q, status_d, sts_we;
  logic pulse_q, pulse_d;
  logic msg_q;
  logic active, msg_rise, deliver;

  always_comb begin
    active   = mode_i.en & glb_en;
    msg_rise = mode_i.msg & ~msg_q;
    deliver  = fire_i & active & ~mode_i.msg;
    sts_we   = ~active | msg_rise | deliver | clr_i;
    status_d = status_q;
    if (!active || msg_rise) begin
      status_d = 1'b0;
    end else if (deliver) begin
      status_d = mode_i.level;
    end else if (clr_i) begin
      status_d = 1'b0;
    end
    pulse_d = deliver & ~mode_i.level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
      msg_q    <= 1'b0;
    end else begin
      if (sts_we) status_q <= status_d;
      pulse_q <= pulse_d;
      msg_q   <= mode_i.msg;
    end
  end

  assign status_o = status_q;
  assign pulse_o  = pulse_q;

  // R5
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_i.en && glb_en) |=> !status_q);

  // R4
  edge_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !mode_i.level && !mode_i.msg) |=> !status_q);

  // R6
  msg_on_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_i.msg) |=> (!status_q && !pulse_q));
endmodule

// File: rtl/tir_legacy.sv
module tir_legacy (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy_en,
  input  logic pit_in,
  input  logic rtc_in,
  output logic pit_fwd_o,
  output logic rtc_rec_o
);
  logic pit_seen_q;
  logic pit_fwd_q, pit_fwd_d;
  logic rtc_rec_q;

  always_comb begin
    if (legacy_en) begin
      pit_fwd_d = 1'b0;
    end else if (pit_in != pit_seen_q) begin
      pit_fwd_d = pit_in;
    end else begin
      pit_fwd_d = pit_fwd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_seen_q <= 1'b0;
      pit_fwd_q  <= 1'b0;
      rtc_rec_q  <= 1'b0;
    end else begin
      pit_seen_q <= pit_in;
      pit_fwd_q  <= pit_fwd_d;
      rtc_rec_q  <= rtc_in;
    end
  end

  assign pit_fwd_o = pit_fwd_q;
  assign rtc_rec_o = rtc_rec_q;

  // R7
  pit_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_en |=> !pit_fwd_q);

  // R8
  rtc_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_en |=> (rtc_rec_q == $past(rtc_in)));
endmodule

// File: rtl/tir_merge.sv
module tir_merge #(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LEG_LINE0 = 0,
  parameter int unsigned LEG_LINE1 = 8,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        legacy_en,
  input  logic [NUM_CH-1:0]           src_act_i,
  input  logic [NUM_CH*ROUTE_W-1:0]   route_i,
  input  logic                        pit_fwd_i,
  input  logic                        rtc_rec_i,
  output logic [NUM_LINES-1:0]        irq_o
);
  localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0][NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] irq_d, irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ROUTE_W-1:0] tgt;
    if (c == 0) begin : g_leg0
      assign tgt = legacy_en ? ROUTE_W'(LEG_LINE0) : route_i[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_leg1
      assign tgt = legacy_en ? ROUTE_W'(LEG_LINE1) : route_i[c*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign tgt = route_i[c*ROUTE_W +: ROUTE_W];
    end
    assign hit[c] = src_act_i[c] ? (ONE << tgt) : '0;
  end

  always_comb begin
    irq_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      irq_d = irq_d | hit[c];
    end
    if (!legacy_en) begin
      irq_d[LEG_LINE0] = irq_d[LEG_LINE0] | pit_fwd_i;
      irq_d[LEG_LINE1] = irq_d[LEG_LINE1] | rtc_rec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R8
  rtc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en && src_act_i == '0) |=> !irq_q[LEG_LINE1]);

  // R7
  pit_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en && src_act_i == '0) |=> !irq_q[LEG_LINE0]);
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tir_pkg::*;
#(
  parameter int unsigned NUM_CH    = TIR_NUM_CH,
  parameter int unsigned NUM_LINES = TIR_NUM_LINES,
  parameter int unsigned LEG_LINE0 = TIR_LEG_LINE0,
  parameter int unsigned LEG_LINE1 = TIR_LEG_LINE1,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      glb_en,
  input  logic                      legacy_en,
  input  logic [NUM_CH-1:0]         tmr_fire,
  input  logic [NUM_CH-1:0]         tmr_en,
  input  logic [NUM_CH-1:0]         tmr_level,
  input  logic [NUM_CH-1:0]         tmr_msg,
  input  logic [NUM_CH*ROUTE_W-1:0] tmr_route,
  input  logic [NUM_CH-1:0]         sts_clr,
  input  logic                      pit_in,
  input  logic                      rtc_in,
  output logic [NUM_LINES-1:0]      irq_out,
  output logic [NUM_CH-1:0]         sts_out
);
  logic rst_meta_q, rst_sync_q;
  logic [NUM_CH-1:0] status, pulse, src_act;
  logic pit_fwd, rtc_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ch_mode_t mode;
    assign mode = '{en: tmr_en[c], level: tmr_level[c], msg: tmr_msg[c]};
    tir_chan i_chan (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .glb_en   (glb_en),
      .fire_i   (tmr_fire[c]),
      .clr_i    (sts_clr[c]),
      .mode_i   (mode),
      .status_o (status[c]),
      .pulse_o  (pulse[c])
    );
  end

  assign src_act = (status | pulse) & ~tmr_msg;

  tir_legacy i_legacy (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .legacy_en (legacy_en),
    .pit_in    (pit_in),
    .rtc_in    (rtc_in),
    .pit_fwd_o (pit_fwd),
    .rtc_rec_o (rtc_rec)
  );

  tir_merge #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .LEG_LINE0 (LEG_LINE0),
    .LEG_LINE1 (LEG_LINE1)
  ) i_merge (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .legacy_en (legacy_en),
    .src_act_i (src_act),
    .route_i   (tmr_route),
    .pit_fwd_i (pit_fwd),
    .rtc_rec_i (rtc_rec),
    .irq_o     (irq_out)
  );

  assign sts_out = status;

  // R6
  msg_no_line_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (tmr_msg == '1 && !pit_fwd && !rtc_rec) |=> (irq_out == '0));
endmodule

// File: tb/test_tmr_irq_router.sv
`timescale 1ns/1ps
module test_tmr_irq_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en, legacy_en, pit_in, rtc_in;
  logic [2:0]  tmr_fire, tmr_en, tmr_level, tmr_msg, sts_clr;
  logic [14:0] tmr_route;
  logic [31:0] irq_out;
  logic [2:0]  sts_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  logic [2:0]  m_sts, m_pulse, m_msgp;
  logic        m_pitfwd, m_pitseen, m_rtc;
  logic [31:0] m_irq;

  always #5 clk = ~clk;

  tmr_irq_router i_tmr_irq_router (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
    .tmr_fire(tmr_fire), .tmr_en(tmr_en), .tmr_level(tmr_level),
    .tmr_msg(tmr_msg), .tmr_route(tmr_route), .sts_clr(sts_clr),
    .pit_in(pit_in), .rtc_in(rtc_in), .irq_out(irq_out), .sts_out(sts_out)
  );

  function automatic int tgt(int c);
    if (legacy_en && c == 0) return 0;
    if (legacy_en && c == 1) return 8;
    return int'(tmr_route[c*5 +: 5]);
  endfunction

  always @(posedge clk) begin
    logic [31:0] nx;
    logic        act;
    if (!rst_n) begin
      m_sts = '0; m_pulse = '0; m_msgp = '0;
      m_pitfwd = 0; m_pitseen = 0; m_rtc = 0; m_irq = '0;
    end else begin
      nx = '0;
      for (int c = 0; c < 3; c++)
        if ((m_sts[c] | m_pulse[c]) && !tmr_msg[c]) nx[tgt(c)] = 1'b1;
      if (!legacy_en) begin
        nx[0] = nx[0] | m_pitfwd;
        nx[8] = nx[8] | m_rtc;
      end
      for (int c = 0; c < 3; c++) begin
        act = tmr_en[c] & glb_en;
        m_pulse[c] = tmr_fire[c] & act & ~tmr_msg[c] & ~tmr_level[c];
        if (!act || (tmr_msg[c] && !m_msgp[c])) m_sts[c] = 1'b0;
        else if (tmr_fire[c] && !tmr_msg[c]) m_sts[c] = tmr_level[c];
        else if (sts_clr[c]) m_sts[c] = 1'b0;
        m_msgp[c] = tmr_msg[c];
      end
      if (legacy_en) m_pitfwd = 1'b0;
      else if (pit_in != m_pitseen) m_pitfwd = pit_in;
      m_pitseen = pit_in;
      m_rtc = rtc_in;
      m_irq = nx;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic step(string req);
    @(negedge clk);
    check(req, irq_out, m_irq, "irq_out");
    check(req, {29'd0, sts_out}, {29'd0, m_sts}, "sts_out");
  endtask

  task automatic steps(string req, int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic idle();
    glb_en = 0; legacy_en = 0; pit_in = 0; rtc_in = 0;
    tmr_fire = 0; tmr_en = 0; tmr_level = 0; tmr_msg = 0; sts_clr = 0;
    tmr_route = '0;
  endtask

  task automatic fire(string req, logic [2:0] f);
    tmr_fire = f; step(req); tmr_fire = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", irq_out, 32'h0, "irq_out in reset");
    check("R10", {29'd0, sts_out}, 32'h0, "sts_out in reset");
    rst_n = 1;
    steps("R10", 4);

    // R1 routing, level channel 2 to line 17
    glb_en = 1; tmr_en = 3'b111; tmr_level = 3'b100;
    tmr_route = {5'd17, 5'd3, 5'd12};
    fire("R1", 3'b100);
    steps("R1", 3);
    check("R1", irq_out, 32'h0002_0000, "line 17 only");
    // R3 hold then clear
    steps("R3", 3);
    sts_clr = 3'b100; step("R3"); sts_clr = 0;
    steps("R3", 3);
    // R3 fire and clear together: fire wins
    tmr_fire = 3'b100; sts_clr = 3'b100; step("R3");
    tmr_fire = 0; sts_clr = 0; steps("R3", 2);
    check("R3", {29'd0, sts_out}, 32'h4, "fire beats clear");
    sts_clr = 3'b100; step("R3"); sts_clr = 0; steps("R3", 2);

    // R4 edge channels 0 and 1
    tmr_level = 3'b000;
    fire("R4", 3'b011);
    steps("R4", 4);

    // R2 legacy override, level
    tmr_level = 3'b111; legacy_en = 1;
    tmr_route = {5'd20, 5'd6, 5'd5};
    fire("R2", 3'b111);
    steps("R2", 2);
    check("R2", irq_out, 32'h0010_0101, "lines 0,8,20");
    legacy_en = 0; steps("R1", 2);
    sts_clr = 3'b111; step("R2"); sts_clr = 0; steps("R2", 2);

    // R5 disabled and global off
    tmr_en = 3'b000; fire("R5", 3'b111); steps("R5", 3);
    tmr_en = 3'b111; fire("R5", 3'b111); steps("R5", 2);
    glb_en = 0; steps("R5", 3);
    check("R5", irq_out, 32'h0, "global off drops lines");
    glb_en = 1;

    // R6 message delivery
    tmr_msg = 3'b001; fire("R6", 3'b001); steps("R6", 3);
    tmr_msg = 0; fire("R6", 3'b010); steps("R6", 2);
    tmr_msg = 3'b010; steps("R6", 3);
    tmr_msg = 0; steps("R6", 2);

    // R7 timer pass-through
    pit_in = 1; steps("R7", 3);
    legacy_en = 1; steps("R7", 3);
    legacy_en = 0; steps("R7", 3);
    check("R7", irq_out, 32'h0, "no line 0 without new edge");
    pit_in = 0; steps("R7", 2); pit_in = 1; steps("R7", 3); pit_in = 0; steps("R7", 3);

    // R8 clock pass-through and record
    rtc_in = 1; steps("R8", 3);
    legacy_en = 1; steps("R8", 2);
    rtc_in = 0; step("R8"); rtc_in = 1; steps("R8", 2);
    legacy_en = 0; step("R8");
    check("R8", irq_out, 32'h100, "line 8 restored");
    rtc_in = 0; steps("R8", 3);

    // R9 shared lines
    tmr_level = 3'b101; tmr_route = {5'd0, 5'd9, 5'd0};
    pit_in = 1; fire("R9", 3'b101); steps("R9", 3);
    sts_clr = 3'b001; steps("R9", 2); sts_clr = 0; steps("R9", 2);
    pit_in = 0; sts_clr = 3'b111; steps("R9", 2); sts_clr = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tmr_fire  = 3'($urandom) & 3'($urandom);
      sts_clr   = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      if ($urandom % 16 == 0) tmr_en    = 3'($urandom) | 3'($urandom);
      if ($urandom % 16 == 0) tmr_level = 3'($urandom);
      if ($urandom % 24 == 0) tmr_msg   = 3'($urandom) & 3'($urandom);
      if ($urandom % 12 == 0) tmr_route = 15'($urandom) & 15'b01001_01001_01001;
      if ($urandom % 30 == 0) glb_en    = ($urandom % 5 != 0);
      if ($urandom % 20 == 0) legacy_en = ~legacy_en;
      if ($urandom % 9 == 0)  pit_in    = ~pit_in;
      if ($urandom % 7 == 0)  rtc_in    = ~rtc_in;
      step("R9");
    end

    // R10 reset clears recorded clock level
    tmr_fire = 0; sts_clr = 0; legacy_en = 1; rtc_in = 1; steps("R10", 2);
    rtc_in = 0; rst_n = 0; @(negedge clk);
    rst_n = 1; legacy_en = 1; steps("R10", 4);
    idle(); legacy_en = 1; steps("R10", 2); legacy_en = 0; steps("R10", 2);
    check("R10", irq_out, 32'h0, "no stale clock level");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule